// File: doc/BRIEF.md
# Power-Aware Sharer-Vector Directory Controller

This block keeps coherence for a shared, inclusive cache that sits behind a set of private write-through first-level caches, one per core. Each line of the shared cache carries a presence flag, a modified flag and one sharer bit per core. Cores send read and write requests. The controller starts a main-memory fetch for every request as soon as it accepts it. It cancels that fetch on the next cycle when the shared cache already holds the line. On a miss it waits for the memory data and installs the line unmodified.

When a core writes, the controller marks the line modified and then walks the other sharers of that line, one per cycle from the lowest core index upward. A sharer whose core is awake receives the new data. A sharer whose core is powered down receives an invalidate, and its sharer bit is cleared, so later writes to that line send it nothing. The controller accepts no new request until this walk has finished. Among requests that arrive together, the lowest core index wins.

Top module: `dir_ctrl_sharevec`

## Requirements
- R1: After reset every line is absent, and the outputs req_ack, resp_valid, msg_valid, mem_req and mem_abort are all low.
- R2: In the cycle a request is accepted, mem_req is high and mem_addr equals the request address. mem_abort pulses in the following cycle exactly when the line is present, and stays low on a miss.
- R3: A read that misses is served from mem_rdata. The response carries that data with resp_dirty low, and resp_valid is one-hot on the requesting core.
- R4: Every completed access sets the requester's sharer bit, so a later write by another core reaches it with a message.
- R5: A write leaves the line modified. Its response returns the written data with resp_dirty high, whether the write hits or misses.
- R6: A write sends messages only to cores other than the writer whose sharer bit is set. A write that misses sends none.
- R7: A sharer whose core_sleep bit is high gets msg_kind 1 (invalidate), and its sharer bit is cleared. It gets no message from later writes until it accesses the line again.
- R8: An awake sharer gets msg_kind 0 (update) with msg_data equal to the written data and msg_addr equal to the line address, and keeps its sharer bit.
- R9: Fan-out messages appear one per cycle on consecutive cycles, in ascending core index order, after the write response.
- R10: When several cores request in the same cycle, the lowest index is acknowledged first. No request is acknowledged while fan-out messages are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N | Request pending per core, held until acknowledged |
| req_write | input | N | Per core: 1 = write, 0 = read |
| req_addr | input | N*AW | Per-core line address, core i at bits i*AW upward |
| req_wdata | input | N*DW | Per-core write data, core i at bits i*DW upward |
| req_ack | output | N | One-hot acceptance of a request |
| resp_valid | output | N | One-hot response strobe to the requester |
| resp_data | output | DW | Line data after the access |
| resp_dirty | output | 1 | Modified flag of the line after the access |
| core_sleep | input | N | Per core: 1 = powered down |
| msg_valid | output | 1 | Fan-out message valid |
| msg_core | output | log2(N) | Destination core of the message |
| msg_kind | output | 1 | 0 = update, 1 = invalidate |
| msg_addr | output | AW | Line address of the message |
| msg_data | output | DW | Updated line data |
| mem_req | output | 1 | Main-memory fetch request |
| mem_addr | output | AW | Fetch address |
| mem_abort | output | 1 | Cancels the fetch issued the cycle before |
| mem_rvalid | input | 1 | Fetch data valid |
| mem_rdata | input | DW | Fetch data |

## Verification
The bench runs a set of access patterns on a few lines: reads that fill and reads that hit, writes whose sharers are all awake, some asleep or all asleep, and writes that miss. Fill versus hit is told apart by the abort pulse and by the data source. Awake versus sleeping sharers are told apart by the message kind and by which cores the next write to the same line reaches. Two cores requesting together while a write fans out show the index priority. The same pattern shows that the second request is held off until the last message has gone out.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_FILL = 2'd2,
      ST_FAN  = 2'd3
   } dir_state_e;

   typedef enum logic {
      MSG_UPD = 1'b0,
      MSG_INV = 1'b1
   } msg_kind_e;
endpackage

// File: rtl/dir_pick_lowest.sv
module dir_pick_lowest #(
   parameter int W = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          any
);
   generate
      if (W < 2) begin : g_bad_width
         $error("dir_pick_lowest: W must be at least 2");
      end
   endgenerate

   always_comb begin
      onehot = '0;
      idx    = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            idx       = IW'(i);
         end
      end
   end

   assign any = |vec;
endmodule

// File: rtl/dir_store.sv
module dir_store #(
   parameter int N  = 4,
   parameter int AW = 3,
   parameter int DW = 16,
   localparam int LINES = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   output logic          rd_valid,
   output logic          rd_dirty,
   output logic [N-1:0]  rd_share,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic          wr_valid,
   input  logic          wr_dirty,
   input  logic [N-1:0]  wr_share,
   input  logic [DW-1:0] wr_data
);
   logic          v_q [LINES];
   logic          d_q [LINES];
   logic [N-1:0]  s_q [LINES];
   logic [DW-1:0] x_q [LINES];

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("dir_store: AW must lie in 1..10");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dir_store: DW must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            v_q[i] <= 1'b0;
            d_q[i] <= 1'b0;
            s_q[i] <= '0;
            x_q[i] <= '0;
         end
      end else if (wr_en) begin
         v_q[addr] <= wr_valid;
         d_q[addr] <= wr_dirty;
         s_q[addr] <= wr_share;
         x_q[addr] <= wr_data;
      end
   end

   assign rd_valid = v_q[addr];
   assign rd_dirty = d_q[addr];
   assign rd_share = s_q[addr];
   assign rd_data  = x_q[addr];
endmodule

// File: rtl/dir_ctrl_sharevec.sv
module dir_ctrl_sharevec
   import dir_pkg::*;
#(
   parameter int N  = 4,
   parameter int AW = 3,
   parameter int DW = 16,
   localparam int CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req_valid,
   input  logic [N-1:0]    req_write,
   input  logic [N*AW-1:0] req_addr,
   input  logic [N*DW-1:0] req_wdata,
   output logic [N-1:0]    req_ack,
   output logic [N-1:0]    resp_valid,
   output logic [DW-1:0]   resp_data,
   output logic            resp_dirty,
   input  logic [N-1:0]    core_sleep,
   output logic            msg_valid,
   output logic [CW-1:0]   msg_core,
   output logic            msg_kind,
   output logic [AW-1:0]   msg_addr,
   output logic [DW-1:0]   msg_data,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_abort,
   input  logic            mem_rvalid,
   input  logic [DW-1:0]   mem_rdata
);
   generate
      if (N < 2 || N > 64) begin : g_bad_n
         $error("dir_ctrl_sharevec: N must lie in 2..64");
      end
   endgenerate

   dir_state_e    state_q, state_d;
   logic [N-1:0]  cur_oh_q;
   logic          cur_wr_q;
   logic [AW-1:0] cur_addr_q;
   logic [DW-1:0] cur_wdata_q;
   logic [N-1:0]  pend_q, pend_d;

   logic [N-1:0]  grant_oh, fan_oh;
   logic [CW-1:0] grant_idx, fan_idx;
   logic          grant_any, fan_any;

   logic          rd_valid, rd_dirty;
   logic [N-1:0]  rd_share;
   logic [DW-1:0] rd_data;
   logic          wr_en, wr_valid, wr_dirty;
   logic [N-1:0]  wr_share;
   logic [DW-1:0] wr_data;

   dir_pick_lowest #(.W(N)) u_arb (
      .vec(req_valid), .onehot(grant_oh), .idx(grant_idx), .any(grant_any)
   );

   dir_pick_lowest #(.W(N)) u_fan (
      .vec(pend_q), .onehot(fan_oh), .idx(fan_idx), .any(fan_any)
   );

   dir_store #(.N(N), .AW(AW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .addr(cur_addr_q),
      .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_share(rd_share), .rd_data(rd_data),
      .wr_en(wr_en), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
      .wr_share(wr_share), .wr_data(wr_data)
   );

   always_comb begin
      state_d    = state_q;
      pend_d     = pend_q;
      req_ack    = '0;
      resp_valid = '0;
      resp_data  = '0;
      resp_dirty = 1'b0;
      msg_valid  = 1'b0;
      msg_core   = '0;
      msg_kind   = MSG_UPD;
      msg_addr   = '0;
      msg_data   = '0;
      mem_req    = 1'b0;
      mem_addr   = '0;
      mem_abort  = 1'b0;
      wr_en      = 1'b0;
      wr_valid   = rd_valid;
      wr_dirty   = rd_dirty;
      wr_share   = rd_share;
      wr_data    = rd_data;
      unique case (state_q)
         ST_IDLE: begin
            if (grant_any) begin
               req_ack  = grant_oh;
               mem_req  = 1'b1;
               mem_addr = req_addr[grant_idx*AW +: AW];
               state_d  = ST_LOOK;
            end
         end
         ST_LOOK: begin
            if (rd_valid) begin
               mem_abort  = 1'b1;
               wr_en      = 1'b1;
               wr_valid   = 1'b1;
               wr_dirty   = rd_dirty | cur_wr_q;
               wr_share   = rd_share | cur_oh_q;
               wr_data    = cur_wr_q ? cur_wdata_q : rd_data;
               resp_valid = cur_oh_q;
               resp_data  = wr_data;
               resp_dirty = wr_dirty;
               pend_d     = cur_wr_q ? (rd_share & ~cur_oh_q) : '0;
               state_d    = (pend_d != '0) ? ST_FAN : ST_IDLE;
            end else begin
               state_d = ST_FILL;
            end
         end
         ST_FILL: begin
            if (mem_rvalid) begin
               wr_en      = 1'b1;
               wr_valid   = 1'b1;
               wr_dirty   = cur_wr_q;
               wr_share   = cur_oh_q;
               wr_data    = cur_wr_q ? cur_wdata_q : mem_rdata;
               resp_valid = cur_oh_q;
               resp_data  = wr_data;
               resp_dirty = wr_dirty;
               state_d    = ST_IDLE;
            end
         end
         ST_FAN: begin
            if (fan_any) begin
               msg_valid = 1'b1;
               msg_core  = fan_idx;
               msg_addr  = cur_addr_q;
               msg_data  = rd_data;
               if (core_sleep[fan_idx]) begin
                  msg_kind = MSG_INV;
                  wr_en    = 1'b1;
                  wr_share = rd_share & ~fan_oh;
               end
            end
            pend_d  = pend_q & ~fan_oh;
            state_d = (pend_d == '0) ? ST_IDLE : ST_FAN;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_q      <= '0;
         cur_oh_q    <= '0;
         cur_wr_q    <= 1'b0;
         cur_addr_q  <= '0;
         cur_wdata_q <= '0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         if (state_q == ST_IDLE && grant_any) begin
            cur_oh_q    <= grant_oh;
            cur_wr_q    <= req_write[grant_idx];
            cur_addr_q  <= req_addr[grant_idx*AW +: AW];
            cur_wdata_q <= req_wdata[grant_idx*DW +: DW];
         end
      end
   end
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] req_ack,
   input logic [N-1:0] resp_valid,
   input logic         msg_valid,
   input logic         mem_req,
   input logic         mem_abort
);
   // R2
   ack_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ack != '0) |-> mem_req);

   // R2
   abort_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_abort |-> $past(mem_req));

   // R10
   single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ack));

   // R10
   no_ack_in_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (req_ack == '0));

   // R3
   single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(resp_valid));

   // R9
   resp_before_msgs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (resp_valid == '0));
endmodule

bind dir_ctrl_sharevec dir_ctrl_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .resp_valid(resp_valid),
   .msg_valid(msg_valid), .mem_req(mem_req), .mem_abort(mem_abort)
);

// File: tb/sim_dir_ctrl_sharevec.sv
module sim_dir_ctrl_sharevec;
   localparam int N  = 4;
   localparam int AW = 3;
   localparam int DW = 16;
   localparam int CW = 2;
   localparam int LINES = 1 << AW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [N-1:0]    req_write = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic [N*DW-1:0] req_wdata = '0;
   logic [N-1:0]    req_ack;
   logic [N-1:0]    resp_valid;
   logic [DW-1:0]   resp_data;
   logic            resp_dirty;
   logic [N-1:0]    core_sleep = '0;
   logic            msg_valid;
   logic [CW-1:0]   msg_core;
   logic            msg_kind;
   logic [AW-1:0]   msg_addr;
   logic [DW-1:0]   msg_data;
   logic            mem_req;
   logic [AW-1:0]   mem_addr;
   logic            mem_abort;
   logic            mem_rvalid = 1'b0;
   logic [DW-1:0]   mem_rdata = '0;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   bit            mv [LINES];
   bit            mdirty [LINES];
   logic [N-1:0]  msh [LINES];
   logic [DW-1:0] mdat [LINES];

   dir_ctrl_sharevec #(.N(N), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .resp_valid(resp_valid), .resp_data(resp_data), .resp_dirty(resp_dirty),
      .core_sleep(core_sleep), .msg_valid(msg_valid), .msg_core(msg_core),
      .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_data(msg_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_abort(mem_abort),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic do_req(input int c, input bit wr, input int a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] md,
                         input int oc, input int oa);
      bit hit, edirty, ab, rseen, oseen, maddr_ok, rdirty;
      logic [DW-1:0] edat, rdat, odat;
      int en, nm, ack_c, oack_c, last_msg;
      int ecore [N];
      bit ekind [N];
      int rcore [8];
      bit rkind [8];
      logic [DW-1:0] rmd [8];
      logic [AW-1:0] rma [8];
      int rcyc [8];
      hit = mv[a];
      if (!hit) begin mv[a] = 1; mdat[a] = md; mdirty[a] = 0; msh[a] = '0; end
      if (wr) begin mdat[a] = wd; mdirty[a] = 1; end
      msh[a][c] = 1'b1;
      edat = mdat[a]; edirty = mdirty[a]; en = 0;
      if (wr) begin
         for (int j = 0; j < N; j++) begin
            if (j != c && msh[a][j]) begin
               ecore[en] = j; ekind[en] = core_sleep[j]; en++;
               if (core_sleep[j]) msh[a][j] = 1'b0;
            end
         end
      end
      @(negedge clk);
      req_valid[c] = 1'b1; req_write[c] = wr;
      req_addr[c*AW +: AW] = a[AW-1:0]; req_wdata[c*DW +: DW] = wd;
      if (oc >= 0) begin
         req_valid[oc] = 1'b1; req_write[oc] = 1'b0; req_addr[oc*AW +: AW] = oa[AW-1:0];
      end
      ack_c = -1; oack_c = -1; ab = 0; nm = 0; rseen = 0; oseen = 0;
      maddr_ok = 0; last_msg = -1; rdat = '0; odat = '0; rdirty = 0;
      for (int cyc = 0; cyc < 30; cyc++) begin
         #1;
         if (req_ack[c]) begin ack_c = cyc; maddr_ok = mem_req && (mem_addr == a[AW-1:0]); end
         if (oc >= 0 && req_ack[oc]) oack_c = cyc;
         if (mem_abort && ack_c >= 0 && cyc == ack_c + 1) ab = 1;
         if (resp_valid[c] && !rseen) begin rseen = 1; rdat = resp_data; rdirty = resp_dirty; end
         if (oc >= 0 && resp_valid[oc]) begin oseen = 1; odat = resp_data; end
         if (msg_valid && nm < 8) begin
            rcore[nm] = int'(msg_core); rkind[nm] = msg_kind; rmd[nm] = msg_data;
            rma[nm] = msg_addr; rcyc[nm] = cyc; nm++; last_msg = cyc;
         end
         @(negedge clk);
         if (ack_c == cyc) req_valid[c] = 1'b0;
         if (oc >= 0 && oack_c == cyc) req_valid[oc] = 1'b0;
         mem_rvalid = (ack_c >= 0 && cyc + 1 == ack_c + 2 && !ab);
         mem_rdata  = md;
      end
      chk(ack_c >= 0, "R10", "request acknowledged", 64'(ack_c >= 0), 1);
      chk(maddr_ok, "R2", "fetch issued with request address", 64'(maddr_ok), 1);
      chk(ab == hit, "R2", "abort exactly on hit", 64'(ab), 64'(hit));
      chk(rseen && rdat == edat, wr ? "R5" : "R3", "response data", 64'(rdat), 64'(edat));
      chk(rdirty == edirty, wr ? "R5" : "R3", "response dirty flag", 64'(rdirty), 64'(edirty));
      chk(nm == en, "R4/R6", "message count", 64'(nm), 64'(en));
      for (int i = 0; i < nm && i < en; i++) begin
         chk(rcore[i] == ecore[i], "R9", "message destination order", 64'(rcore[i]), 64'(ecore[i]));
         chk(rkind[i] == ekind[i], ekind[i] ? "R7" : "R8", "message kind", 64'(rkind[i]), 64'(ekind[i]));
         chk(rmd[i] == wd && rma[i] == a[AW-1:0], "R8", "message data/address",
             {rma[i], rmd[i]}, {a[AW-1:0], wd});
         if (i > 0)
            chk(rcyc[i] == rcyc[i-1] + 1, "R9", "one message per cycle", 64'(rcyc[i]), 64'(rcyc[i-1] + 1));
      end
      if (oc >= 0) begin
         chk(oack_c > ack_c && oack_c > last_msg, "R10", "second request held off",
             64'(oack_c), 64'(last_msg + 1));
         msh[oa][oc] = 1'b1;
         chk(oseen && odat == mdat[oa], "R10", "second request served", 64'(odat), 64'(mdat[oa]));
      end
   endtask

   task automatic t_reset();
      for (int i = 0; i < LINES; i++) begin mv[i] = 0; mdirty[i] = 0; msh[i] = '0; mdat[i] = '0; end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(req_ack == '0 && resp_valid == '0, "R1", "idle ack/resp after reset", {req_ack, resp_valid}, 0);
      chk(!msg_valid && !mem_req && !mem_abort, "R1", "idle msg/mem after reset",
          {msg_valid, mem_req, mem_abort}, 0);
   endtask

   task automatic t_read_fill();   // R1 R3: first access to a line misses and fills clean
      do_req(0, 0, 3, 16'h0000, 16'hA5C3, -1, 0);
   endtask

   task automatic t_read_hits();   // R4: readers join the sharer vector
      do_req(1, 0, 3, 16'h0000, 16'hDEAD, -1, 0);
      do_req(2, 0, 3, 16'h0000, 16'hDEAD, -1, 0);
   endtask

   task automatic t_write_mixed_power();   // R7 R8
      core_sleep = 4'b0100;
      do_req(0, 1, 3, 16'h1234, 16'hDEAD, -1, 0);
   endtask

   task automatic t_sleeper_dropped();   // R7: woken core gets nothing further
      core_sleep = 4'b0000;
      do_req(1, 1, 3, 16'h5678, 16'hDEAD, -1, 0);
   endtask

   task automatic t_write_miss();   // R5 R6
      do_req(3, 1, 5, 16'h0F0F, 16'hBEEF, -1, 0);
      do_req(0, 0, 5, 16'h0000, 16'hBEEF, -1, 0);
   endtask

   task automatic t_blocked_during_fanout();   // R10
      do_req(1, 1, 5, 16'h7777, 16'hBEEF, 2, 3);
   endtask

   task automatic t_all_asleep();   // R7
      core_sleep = 4'b1101;
      do_req(1, 1, 5, 16'h2222, 16'hBEEF, -1, 0);
      core_sleep = 4'b0000;
      do_req(1, 1, 5, 16'h3333, 16'hBEEF, -1, 0);
   endtask

   initial begin
      t_reset();
      t_read_fill();
      t_read_hits();
      t_write_mixed_power();
      t_sleeper_dropped();
      t_write_miss();
      t_blocked_during_fanout();
      t_all_asleep();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         vectors++; miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule